// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and walks the memory from power-up to an idle, configured state. After reset is released it holds the command bus at NOP for a power-up window, closes every bank with a single precharge, runs two auto refresh cycles, and then writes the mode word. Every gap between those commands is filled with NOPs, and each gap length is a cycle-count parameter. The designer sets these counts from the clock period.

Once the wait after the mode write has run out, `init_done` rises and the block releases the bus to COMMAND INHIBIT. The controller logic that follows watches `init_done` before it issues any command of its own. The mode word is a parameter. Address bit 10 and every bit above it are driven low during the mode write, whatever the parameter holds.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, the bus carries COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n} = 1111), with `addr` = 0, `bank` = 0 and `init_done` low.
- R2: For the first PWRUP_CYC clock edges after reset release (PWRUP_CYC is at least 1) the bus carries NOP (0111), with `addr` and `bank` at 0.
- R3: At edge PWRUP_CYC+1 a PRECHARGE (0010) is issued with `addr` bit 10 high, every other address bit low and `bank` = 0.
- R4: Exactly two AUTO REFRESH commands (0001, `addr` = 0, `bank` = 0) follow. The first comes T_RP cycles after the precharge and the second T_RC cycles after the first.
- R5: LOAD MODE (0000) is issued T_RC cycles after the second refresh, with `bank` = 0. On `addr`, bits 9..0 equal MODE_WORD bits 9..0 and bits 10 and above are forced to 0.
- R6: Every cycle between two commands of R3 to R5, and between LOAD MODE and completion, carries NOP with `addr` and `bank` at 0.
- R7: `init_done` rises T_MRD cycles after LOAD MODE and then stays high until reset. While it is high the bus carries COMMAND INHIBIT.
- R8: A reset asserted part-way through the sequence returns the bus to the R1 state, and the whole sequence restarts from R2 on release.
- R9: When a gap parameter is 1, the two commands it separates appear in consecutive cycles, with no NOP between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| bank | output | BA_W | Bank address |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bound checker watches the ordering rules on every cycle. It confirms that nothing but NOP or COMMAND INHIBIT appears before the precharge and that the precharge carries bit 10. It also confirms that a refresh only follows a precharge, that exactly two refreshes precede the mode write, that the reserved mode bits stay low, and that `init_done` is sticky and silences the bus. The exact cycle each command lands on, the NOP fill of each gap, the back-to-back case for one-cycle gaps and the restart after a mid-sequence reset can only be shown by the bench. The bench compares two differently parameterized instances against a cycle-indexed model.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_INHIBIT = 4'b1111;
   localparam logic [3:0] CMD_NOP     = 4'b0111;
   localparam logic [3:0] CMD_PRECHG  = 4'b0010;
   localparam logic [3:0] CMD_REFRESH = 4'b0001;
   localparam logic [3:0] CMD_LDMODE  = 4'b0000;

   // address bit that selects every bank on precharge; also lowest forced-low mode bit
   localparam int unsigned ALLBANK_BIT = 10;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PWRUP,
      PH_PRECHG,
      PH_REF1,
      PH_REF2,
      PH_LDMODE,
      PH_DONE
   } phase_t;

endpackage

// File: rtl/sdram_init_phase_timer.sv
module sdram_init_phase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] len,
   output logic             first,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   assign first = (cnt_q == '0);
   assign last  = (cnt_q == len - 1'b1);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
   import sdram_init_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 13,
   parameter int unsigned        BA_W      = 2,
   parameter logic [ADDR_W-1:0]  MODE_WORD = '0
) (
   input  phase_t            phase,
   input  logic              first,
   output logic [3:0]        cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   bank,
   output logic              done
);

   logic [ADDR_W-1:0] mode_bus;
   logic [ADDR_W-1:0] prechg_bus;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_abits
      if (i < ALLBANK_BIT) begin : g_low
         assign mode_bus[i]   = MODE_WORD[i];
         assign prechg_bus[i] = 1'b0;
      end else if (i == ALLBANK_BIT) begin : g_ap
         assign mode_bus[i]   = 1'b0;
         assign prechg_bus[i] = 1'b1;
      end else begin : g_rsvd
         assign mode_bus[i]   = 1'b0;
         assign prechg_bus[i] = 1'b0;
      end
   end

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      bank = '0;
      done = 1'b0;
      unique case (phase)
         PH_IDLE:   cmd = CMD_INHIBIT;
         PH_PWRUP:  cmd = CMD_NOP;
         PH_PRECHG: if (first) begin
                       cmd  = CMD_PRECHG;
                       addr = prechg_bus;
                    end
         PH_REF1,
         PH_REF2:   if (first) cmd = CMD_REFRESH;
         PH_LDMODE: if (first) begin
                       cmd  = CMD_LDMODE;
                       addr = mode_bus;
                    end
         PH_DONE: begin
            cmd  = CMD_INHIBIT;
            done = 1'b1;
         end
         default:   cmd = CMD_INHIBIT;
      endcase
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 13,
   parameter int unsigned        BA_W      = 2,
   parameter int unsigned        PWRUP_CYC = 25000,
   parameter int unsigned        T_RP      = 5,
   parameter int unsigned        T_RC      = 16,
   parameter int unsigned        T_MRD     = 2,
   parameter logic [ADDR_W-1:0]  MODE_WORD = 'h032
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   bank,
   output logic              init_done
);

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   localparam int unsigned MAX_LEN = max4(PWRUP_CYC, T_RP, T_RC, T_MRD);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   if (ADDR_W <= ALLBANK_BIT) begin : g_bad_addr
      $error("ADDR_W must exceed the all-bank bit position");
   end
   if (BA_W < 1) begin : g_bad_ba
      $error("BA_W must be at least 1");
   end
   if (PWRUP_CYC < 1 || T_RP < 1 || T_RC < 1 || T_MRD < 1) begin : g_bad_time
      $error("every delay parameter must be at least one cycle");
   end

   phase_t           phase_q, phase_d;
   logic [CNT_W-1:0] len;
   logic             first, last, clear;
   logic [3:0]       cmd;

   always_comb begin
      unique case (phase_q)
         PH_PWRUP:  len = CNT_W'(PWRUP_CYC);
         PH_PRECHG: len = CNT_W'(T_RP);
         PH_REF1,
         PH_REF2:   len = CNT_W'(T_RC);
         PH_LDMODE: len = CNT_W'(T_MRD);
         default:   len = CNT_W'(1);
      endcase
   end

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   phase_d = PH_PWRUP;
         PH_PWRUP:  if (last) phase_d = PH_PRECHG;
         PH_PRECHG: if (last) phase_d = PH_REF1;
         PH_REF1:   if (last) phase_d = PH_REF2;
         PH_REF2:   if (last) phase_d = PH_LDMODE;
         PH_LDMODE: if (last) phase_d = PH_DONE;
         default:   phase_d = PH_DONE;
      endcase
   end

   assign clear = (phase_d != phase_q) || (phase_q == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   sdram_init_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .len   (len),
      .first (first),
      .last  (last)
   );

   sdram_init_cmd_enc #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .MODE_WORD (MODE_WORD)
   ) u_enc (
      .phase (phase_q),
      .first (first),
      .cmd   (cmd),
      .addr  (addr),
      .bank  (bank),
      .done  (init_done)
   );

   assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
   import sdram_init_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BA_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [BA_W-1:0]   bank,
   input logic              init_done
);

   logic [3:0] cmd;
   logic       pre_seen;
   logic [1:0] refs;

   assign cmd = {cs_n, ras_n, cas_n, we_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_seen <= 1'b0;
         refs     <= '0;
      end else begin
         if (cmd == CMD_PRECHG) pre_seen <= 1'b1;
         if (cmd == CMD_REFRESH && refs != 2'd3) refs <= refs + 2'd1;
      end
   end

   // R2
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pre_seen && cmd != CMD_PRECHG) |-> ({ras_n, cas_n, we_n} == 3'b111));

   // R3
   prechg_allbank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRECHG) |-> (addr[ALLBANK_BIT] && bank == '0));

   // R4
   ref_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REFRESH) |-> (pre_seen && refs < 2'd2));

   // R4
   ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LDMODE) |-> (refs == 2'd2));

   // R5
   mode_rsvd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LDMODE) |-> (addr[ADDR_W-1:ALLBANK_BIT] == '0 && bank == '0));

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   // R7
   done_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == CMD_INHIBIT));

endmodule

bind sdram_init_seq sdram_init_chk #(
   .ADDR_W (ADDR_W),
   .BA_W   (BA_W)
) u_chk (.*);

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

   localparam int AW = 13;
   localparam int BW = 2;

   // instance A: ordinary gaps
   localparam int A_P = 20, A_RP = 3, A_RC = 7, A_MRD = 2;
   localparam logic [AW-1:0] A_MODE = 13'h1C33;
   // instance B: every delay one cycle
   localparam int B_P = 1, B_RP = 1, B_RC = 1, B_MRD = 1;
   localparam logic [AW-1:0] B_MODE = 13'h0422;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          a_cs, a_ras, a_cas, a_we, a_done;
   logic [AW-1:0] a_addr;
   logic [BW-1:0] a_bank;
   logic          b_cs, b_ras, b_cas, b_we, b_done;
   logic [AW-1:0] b_addr;
   logic [BW-1:0] b_bank;

   sdram_init_seq #(
      .ADDR_W(AW), .BA_W(BW), .PWRUP_CYC(A_P), .T_RP(A_RP),
      .T_RC(A_RC), .T_MRD(A_MRD), .MODE_WORD(A_MODE)
   ) i_sdram_init_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas),
      .we_n(a_we), .addr(a_addr), .bank(a_bank), .init_done(a_done)
   );

   sdram_init_seq #(
      .ADDR_W(AW), .BA_W(BW), .PWRUP_CYC(B_P), .T_RP(B_RP),
      .T_RC(B_RC), .T_MRD(B_MRD), .MODE_WORD(B_MODE)
   ) i_sdram_init_seq_b (
      .clk(clk), .rst_n(rst_n), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas),
      .we_n(b_we), .addr(b_addr), .bank(b_bank), .init_done(b_done)
   );

   int checks = 0;
   int fails  = 0;
   int edges  = 0;   // rising edges seen with reset released
   int cycles = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst_n) edges <= edges + 1;
      else       edges <= 0;
   end

   // behavioural model: expected bus after e edges since release
   task automatic model(input int e, input int p, input int rp, input int rc,
                        input int mrd, input logic [AW-1:0] mode,
                        output logic [3:0] cmd, output logic [AW-1:0] ad,
                        output logic dn, output string req);
      int t_pre, t_r1, t_r2, t_lm, t_dn;
      t_pre = p + 1;
      t_r1  = t_pre + rp;
      t_r2  = t_r1 + rc;
      t_lm  = t_r2 + rc;
      t_dn  = t_lm + mrd;
      ad = '0; dn = 1'b0;
      if (e == 0)            begin cmd = 4'b1111; req = "R1"; end
      else if (e < t_pre)    begin cmd = 4'b0111; req = "R2"; end
      else if (e == t_pre)   begin cmd = 4'b0010; ad = 13'h0400; req = "R3"; end
      else if (e == t_r1 || e == t_r2) begin cmd = 4'b0001; req = "R4"; end
      else if (e == t_lm)    begin cmd = 4'b0000; ad = {3'b000, mode[9:0]}; req = "R5"; end
      else if (e >= t_dn)    begin cmd = 4'b1111; dn = 1'b1; req = "R7"; end
      else                   begin cmd = 4'b0111; req = "R6"; end
   endtask

   task automatic compare(input string who, input string tag,
                          input logic [3:0] got_c, input logic [AW-1:0] got_a,
                          input logic [BW-1:0] got_b, input logic got_d,
                          input logic [3:0] exp_c, input logic [AW-1:0] exp_a,
                          input logic exp_d);
      checks++;
      if (got_c !== exp_c || got_a !== exp_a || got_b !== '0 || got_d !== exp_d) begin
         fails++;
         $display("FAIL %s %s edge %0d: cmd=%b addr=%h bank=%h done=%b expected cmd=%b addr=%h bank=0 done=%b",
                  tag, who, edges, got_c, got_a, got_b, got_d, exp_c, exp_a, exp_d);
      end
   endtask

   // compare both instances on every falling edge (R8, R9 via B, restarts)
   always @(negedge clk) begin
      logic [3:0] ec; logic [AW-1:0] ea; logic ed; string rq;
      model(edges, A_P, A_RP, A_RC, A_MRD, A_MODE, ec, ea, ed, rq);
      compare("A", rq, {a_cs, a_ras, a_cas, a_we}, a_addr, a_bank, a_done, ec, ea, ed);
      model(edges, B_P, B_RP, B_RC, B_MRD, B_MODE, ec, ea, ed, rq);
      if (rq != "R1" && rq != "R7") rq = {rq, "/R9"};
      compare("B", rq, {b_cs, b_ras, b_cas, b_we}, b_addr, b_bank, b_done, ec, ea, ed);
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin : stim
      wait_neg(3);          // R1: reset held
      rst_n = 1'b1;
      wait_neg(12);         // part-way through A's power-up window, B done
      rst_n = 1'b0;         // R8: reset mid-sequence
      wait_neg(2);
      rst_n = 1'b1;
      wait_neg(80);         // full run, then R7 hold
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : watchdog
      wait (cycles > 5000);
      fails++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<=5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule